// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a serial memory reached over a two-wire bus with a clock line and an open-drain data line. It samples both lines with the system clock, finds bus START and STOP conditions, and decodes a device-select byte. For a write transfer it then takes a two-byte memory address and any number of data bytes. Data bytes are collected in a page buffer and copied into a byte-wide register array when the master issues STOP. A timed busy period follows the copy.

Reads may start at the current pointer, at an address loaded by a preceding address-only write and a repeated START, or run on sequentially for as long as the master acknowledges. A write-protect input blocks every commit. While the busy period runs, the block declines its device-select byte, so a master can poll for completion. The array holds 2^AW bytes in pages of 2^PAGE_W bytes. The default busy length is 500000 cycles, which is 5 ms at 100 MHz.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the block does not pull SDA low (`sda_oe` = 0).
- R2: A device-select byte is acknowledged only when bits 7..4 are 1010 and bits 3..1 equal `strap_i`. Bit 0 selects read (1) or write (0). A non-matching byte gets no acknowledge: SDA stays released during the ninth clock.
- R3: The memory address is sent as two bytes, high byte first, forming a 15-bit address. Only its low AW bits select a byte, so the bits above are ignored, including bit 7 of the high byte.
- R4: A data byte in a write transfer is staged at the pointer's low PAGE_W bits, and those bits then increment and wrap inside the page. At STOP only the staged bytes of that page are written. All other bytes keep their contents.
- R5: A STOP that follows at least one complete data byte starts a busy period of exactly WR_CYCLES clock cycles. During that period the device-select byte is not acknowledged. After it ends, the device-select byte is acknowledged again.
- R6: If `wp_i` is high when STOP is detected, the staged bytes are dropped, the array is unchanged and no busy period starts.
- R7: An address-only write followed by a repeated START and a read select returns the byte at the loaded address.
- R8: In a read, the pointer advances after every byte. It wraps from 2^AW-1 to 0, and further bytes follow for as long as the master acknowledges. A master NACK ends the read.
- R9: A read select with no address phase returns the byte at the current pointer, which is one past the last byte read.
- R10: A START or STOP inside a byte discards the partial byte. A STOP with no complete data byte starts no write, and a START loads nothing into the pointer.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| wp_i | input | 1 | Write protect; high blocks every commit |
| strap_i | input | 3 | Device address straps compared with select bits 3..1 |

## Verification
The assertions assume that SCL stays high and low for at least two system clocks per phase. They also assume that the master changes SDA only while SCL is low, except when it makes START or STOP, and that it never issues START or STOP while the block is pulling SDA low. The bench clocks the bus with three-cycle quarter periods and moves SDA only in the low phase. It places START and STOP only where the block has released the line, so the edge-ordering and drive-timing checks stay within those assumptions. Busy-length and write-protect properties then rest on the commit pulse and the busy flag alone.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_MACK,
      ST_WAIT
   } bus_state_e;

   localparam logic [3:0] DEV_PREFIX = 4'b1010;
   localparam int         MEM_ADDR_BITS = 15;
endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("twi_line_sampler: STAGES must be at least 2");
      end
   endgenerate

   // STAGES synchroniser flops plus one history flop per line
   logic [STAGES:0] scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= '1;
         sda_p <= '1;
      end else begin
         scl_p <= {scl_p[STAGES-1:0], scl_i};
         sda_p <= {sda_p[STAGES-1:0], sda_i};
      end
   end

   logic scl_old, sda_old;
   assign scl_s   = scl_p[STAGES-1];
   assign sda_s   = sda_p[STAGES-1];
   assign scl_old = scl_p[STAGES];
   assign sda_old = sda_p[STAGES];

   assign scl_rise  = scl_s & ~scl_old;
   assign scl_fall  = ~scl_s & scl_old;
   assign start_det = scl_s & scl_old & sda_old & ~sda_s;
   assign stop_det  = scl_s & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
   parameter int AW        = 10,
   parameter int PW        = 6,
   parameter int WR_CYCLES = 500000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stage_we,
   input  logic [PW-1:0] stage_idx,
   input  logic [7:0]    stage_data,
   input  logic          buf_clear,
   input  logic          commit,
   input  logic [AW-PW-1:0] commit_page,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic          busy
);
   localparam int DEPTH = 1 << AW;
   localparam int PAGE  = 1 << PW;
   localparam int TW    = $clog2(WR_CYCLES + 1);

   generate
      if (WR_CYCLES < 1) begin : g_bad_wrc
         $error("eeprom_store: WR_CYCLES must be at least 1");
      end
   endgenerate

   logic [7:0]      mem  [DEPTH];
   logic [7:0]      pbuf [PAGE];
   logic [PAGE-1:0] pval;
   logic [TW-1:0]   tmr;

   // which page slots hold a byte of the current transfer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pval <= '0;
      else if (buf_clear || commit) pval <= '0;
      else if (stage_we)          pval[stage_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (stage_we) pbuf[stage_idx] <= stage_data;
   end

   // whole-page copy in one cycle; only marked slots are written
   always_ff @(posedge clk) begin
      if (commit) begin
         for (int j = 0; j < PAGE; j++) begin
            if (pval[j]) mem[{commit_page, PW'(j)}] <= pbuf[j];
         end
      end
   end

   assign rd_data = mem[rd_addr];

   // self-clearing write-cycle timer: busy for exactly WR_CYCLES cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tmr  <= '0;
      end else if (commit) begin
         busy <= 1'b1;
         tmr  <= TW'(WR_CYCLES - 1);
      end else if (busy) begin
         if (tmr == '0) busy <= 1'b0;
         else           tmr  <= tmr - 1'b1;
      end
   end
endmodule

// File: rtl/twi_proto_engine.sv
module twi_proto_engine
   import twi_eeprom_pkg::*;
#(
   parameter int AW = 10,
   parameter int PW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          sda_s,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic          busy,
   input  logic          wp_i,
   input  logic [2:0]    strap_i,
   input  logic [7:0]    rd_data,
   output logic          sda_oe,
   output logic [AW-1:0] ptr,
   output logic          stage_we,
   output logic [PW-1:0] stage_idx,
   output logic [7:0]    stage_data,
   output logic          buf_clear,
   output logic          commit,
   output logic [AW-PW-1:0] commit_page
);
   bus_state_e state, nxt;
   logic [3:0] cnt;
   logic [7:0] sh, tx;
   logic [6:0] hi_q;
   logic       staged, mack;
   logic [MEM_ADDR_BITS-1:0] full_addr;

   assign full_addr   = {hi_q, sh};
   assign commit_page = ptr[AW-1:PW];

   generate
      if (AW < MEM_ADDR_BITS) begin : g_trunc
         logic unused_hi;
         assign unused_hi = ^full_addr[MEM_ADDR_BITS-1:AW];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         nxt        <= ST_IDLE;
         cnt        <= '0;
         sh         <= '0;
         tx         <= '0;
         hi_q       <= '0;
         staged     <= 1'b0;
         mack       <= 1'b0;
         sda_oe     <= 1'b0;
         ptr        <= '0;
         stage_we   <= 1'b0;
         stage_idx  <= '0;
         stage_data <= '0;
         buf_clear  <= 1'b0;
         commit     <= 1'b0;
      end else begin
         stage_we  <= 1'b0;
         buf_clear <= 1'b0;
         commit    <= 1'b0;
         if (start_det) begin
            // (repeated) START: drop partial byte and any staged data
            state     <= ST_DEV;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            staged    <= 1'b0;
            buf_clear <= 1'b1;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
            staged <= 1'b0;
            if (staged) begin
               if (wp_i) buf_clear <= 1'b1;
               else      commit    <= 1'b1;
            end
         end else begin
            unique case (state)
               ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                  if (scl_rise && cnt != 4'd8) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     unique case (state)
                        ST_DEV: begin
                           if (sh[7:1] == {DEV_PREFIX, strap_i} && !busy) begin
                              sda_oe <= 1'b1;
                              nxt    <= sh[0] ? ST_RDAT : ST_AHI;
                              state  <= ST_ACK;
                           end else begin
                              state <= ST_WAIT;
                           end
                        end
                        ST_AHI: begin
                           hi_q   <= sh[6:0];
                           sda_oe <= 1'b1;
                           nxt    <= ST_ALO;
                           state  <= ST_ACK;
                        end
                        ST_ALO: begin
                           ptr    <= full_addr[AW-1:0];
                           sda_oe <= 1'b1;
                           nxt    <= ST_WDAT;
                           state  <= ST_ACK;
                        end
                        default: begin
                           stage_we      <= 1'b1;
                           stage_idx     <= ptr[PW-1:0];
                           stage_data    <= sh;
                           ptr[PW-1:0]   <= ptr[PW-1:0] + 1'b1;
                           staged        <= 1'b1;
                           sda_oe        <= 1'b1;
                           nxt           <= ST_WDAT;
                           state         <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (nxt == ST_RDAT) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                     end else begin
                        sda_oe <= 1'b0;
                     end
                     state <= nxt;
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                        state  <= ST_MACK;
                     end else begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                        cnt    <= cnt + 1'b1;
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  if (scl_fall) begin
                     if (mack) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        cnt    <= '0;
                        state  <= ST_RDAT;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
   parameter int AW          = 10,
   parameter int PAGE_W      = 6,
   parameter int WR_CYCLES   = 500000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic       wp_i,
   input  logic [2:0] strap_i
);
   generate
      if (AW > twi_eeprom_pkg::MEM_ADDR_BITS) begin : g_bad_aw
         $error("twi_eeprom_slave: AW exceeds the 15-bit bus address");
      end
      if (PAGE_W < 1 || PAGE_W >= AW) begin : g_bad_pw
         $error("twi_eeprom_slave: PAGE_W must lie in 1..AW-1");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy, stage_we, buf_clear, commit;
   logic [PAGE_W-1:0]    stage_idx;
   logic [7:0]           stage_data, rd_data;
   logic [AW-1:0]        ptr;
   logic [AW-PAGE_W-1:0] commit_page;

   twi_line_sampler #(.STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   twi_proto_engine #(.AW(AW), .PW(PAGE_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det), .busy(busy),
      .wp_i(wp_i), .strap_i(strap_i), .rd_data(rd_data), .sda_oe(sda_oe),
      .ptr(ptr), .stage_we(stage_we), .stage_idx(stage_idx),
      .stage_data(stage_data), .buf_clear(buf_clear), .commit(commit),
      .commit_page(commit_page)
   );

   eeprom_store #(.AW(AW), .PW(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .stage_we(stage_we), .stage_idx(stage_idx),
      .stage_data(stage_data), .buf_clear(buf_clear), .commit(commit),
      .commit_page(commit_page), .rd_addr(ptr), .rd_data(rd_data), .busy(busy)
   );
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk #(
   parameter int WR_CYCLES = 500000
) (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic sda_oe,
   input logic wp_i,
   input logic commit,
   input logic busy
);
   logic [31:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   // R5
   busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_cnt < 32'(WR_CYCLES));

   // R5
   commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> busy);

   // R6
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !$past(wp_i));

   // R11
   sda_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);
endmodule

bind twi_eeprom_slave twi_eeprom_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
   .wp_i(wp_i), .commit(commit), .busy(busy)
);

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
   localparam int AW = 8, PW = 2, WRC = 200, Q = 3;
   localparam logic [2:0] STRAP = 3'b101;
   localparam int NPAGE = (1 << AW) >> PW;
   localparam int PSZ = 1 << PW;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp = 1'b0;
   logic sda_oe;
   wire  sda_bus = m_sda & ~sda_oe;

   int errs = 0, checks = 0, oe_glitch = 0;
   logic [7:0] rbuf [300];

   twi_eeprom_slave #(.AW(AW), .PAGE_W(PW), .WR_CYCLES(WRC), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_oe(sda_oe), .wp_i(wp), .strap_i(STRAP)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errs++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic w(int n);
      repeat (n) @(negedge clk);
   endtask

   // R11 monitor: drive changes while SCL stays high
   logic pscl = 1'b1, poe = 1'b0;
   always @(posedge clk) begin
      if (rst_n && m_scl && pscl && sda_oe !== poe) oe_glitch++;
      pscl <= m_scl;
      poe  <= sda_oe;
   end

   task automatic i_start();
      m_scl = 0; w(Q); m_sda = 1; w(Q); m_scl = 1; w(2*Q);
      m_sda = 0; w(2*Q); m_scl = 0;
   endtask

   task automatic i_stop();
      m_scl = 0; w(Q); m_sda = 0; w(Q); m_scl = 1; w(2*Q); m_sda = 1; w(2*Q);
   endtask

   task automatic bit_out(logic b);
      w(Q); m_sda = b; w(Q); m_scl = 1; w(2*Q); m_scl = 0;
   endtask

   task automatic bit_in(output logic b);
      w(Q); m_sda = 1; w(Q); m_scl = 1; w(Q); b = sda_bus; w(Q); m_scl = 0;
   endtask

   task automatic send(logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(b);
      ack = ~b;
   endtask

   task automatic recv(logic ack_it, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         d[i] = b;
      end
      bit_out(~ack_it);
   endtask

   function automatic logic [7:0] dev(logic rw);
      return {4'b1010, STRAP, rw};
   endfunction

   task automatic poll(output int nacks);
      logic a;
      nacks = 0;
      for (int i = 0; i < 20; i++) begin
         i_start(); send(dev(0), a); i_stop();
         if (a) break;
         nacks++;
      end
   endtask

   task automatic read_at(int addr, int n, logic [7:0] hi);
      logic a;
      i_start(); send(dev(0), a); chk("R7 select ack", a, 1);
      send(hi, a); send(8'(addr), a);
      i_start(); send(dev(1), a); chk("R7 read select ack", a, 1);
      for (int i = 0; i < n; i++) recv(i < n - 1, rbuf[i]);
      i_stop();
   endtask

   initial begin
      logic a;
      logic [7:0] d;
      int n;
      w(4); rst_n = 1; w(2);
      chk("R1 sda_oe after reset", sda_oe, 0);
      chk("R1 bus high after reset", sda_bus, 1);

      // R2: wrong straps and wrong prefix are not acknowledged
      i_start(); send({4'b1010, ~STRAP, 1'b0}, a); i_stop();
      chk("R2 strap mismatch nack", a, 0);
      i_start(); send({4'b1011, STRAP, 1'b1}, a); i_stop();
      chk("R2 prefix mismatch nack", a, 0);

      // R4/R5/R3: fill every page, starting at a rotating offset
      for (int p = 0; p < NPAGE; p++) begin
         int s = p % PSZ;
         i_start(); send(dev(0), a); chk("R2 write select ack", a, 1);
         send((p % 2) ? 8'(8'h80 | p) : 8'(p), a); chk("R3 addr hi ack", a, 1);
         send(8'(p * PSZ + s), a); chk("R3 addr lo ack", a, 1);
         for (int k = 0; k < PSZ; k++) begin
            send(pat(p * PSZ + ((s + k) % PSZ)), a);
            chk("R4 data ack", a, 1);
         end
         i_stop();
         poll(n);
         chk("R5 busy polls in 1..3", (n >= 1 && n <= 3) ? 1 : 0, 1);
      end

      // R8: sequential read over the whole array plus one wrap byte
      read_at(0, (1 << AW) + 1, 8'hFF);
      for (int i = 0; i <= (1 << AW); i++)
         chk($sformatf("R8 seq byte %0d", i), rbuf[i], pat(i % (1 << AW)));

      // R9: current address read continues after the wrapped byte
      i_start(); send(dev(1), a); chk("R9 select ack", a, 1);
      recv(0, d); i_stop();
      chk("R9 current read", d, pat(1));

      // R4: single staged byte leaves the page neighbours alone
      i_start(); send(dev(0), a); send(8'h00, a); send(8'h21, a); send(8'h5A, a);
      i_stop(); poll(n);
      read_at(8'h20, 4, 8'h00);
      chk("R4 neighbour 0x20", rbuf[0], pat(8'h20));
      chk("R4 written 0x21", rbuf[1], 8'h5A);
      chk("R4 neighbour 0x22", rbuf[2], pat(8'h22));
      chk("R4 neighbour 0x23", rbuf[3], pat(8'h23));

      // R7: random read with nonzero high byte
      read_at(8'h9C, 1, 8'h7F);
      chk("R7 random read", rbuf[0], pat(8'h9C));

      // R6: write protect blocks the commit and the busy period
      wp = 1;
      i_start(); send(dev(0), a); send(8'h00, a); send(8'h30, a); send(~pat(8'h30), a);
      i_stop(); poll(n);
      chk("R6 no busy under wp", n, 0);
      wp = 0;
      read_at(8'h30, 1, 8'h00);
      chk("R6 byte unchanged", rbuf[0], pat(8'h30));

      // R10: STOP inside a data byte
      i_start(); send(dev(0), a); send(8'h00, a); send(8'h40, a);
      bit_out(0); bit_out(0); bit_out(0); bit_out(0);
      i_stop(); poll(n);
      chk("R10 no write after aborted byte", n, 0);
      read_at(8'h40, 1, 8'h00);
      chk("R10 byte unchanged", rbuf[0], pat(8'h40));

      // R10: START inside a data byte, then read from the loaded pointer
      i_start(); send(dev(0), a); send(8'h00, a); send(8'h44, a);
      bit_out(1); bit_out(0); bit_out(1); bit_out(0); bit_out(1);
      i_start(); send(dev(1), a); chk("R10 select after restart", a, 1);
      recv(0, d); i_stop();
      chk("R10 read after restart", d, pat(8'h44));
      poll(n);
      chk("R10 restart left nothing staged", n, 0);

      chk("R11 drive changes with SCL high", oe_glitch, 0);

      summary();
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end
endmodule